// File: doc/BRIEF.md
# Three-Wire Radio Register Master

This block drives a three-wire serial control bus into a radio transceiver. The bus has an active-low frame enable, a serial clock, and one data line that the master drives during address and write bits and releases for read data. A read/write flag pin goes with the bus. A host asks for a transfer through a request/acknowledge port. A write carries a 4-bit register address and 12 data bits. A read carries a 5-bit address and returns 12 bits with a one-cycle valid strobe.

Every bus phase is a whole number of timing units. One unit lasts `DIV` clock cycles. The enable pulse, the setup time and the hold time are each set in units by parameters, so the bus timing can be tuned to the radio. If the host asks for it, a write is followed by a readback of the same register. When the upper five data bits of the readback differ from the written value, the write is issued once more. The host sees busy for the whole chain and one done pulse at its end.

Top module: `rf3w_master`

## Requirements
- R1: During and after reset the bus idles with enable high, clock low, data released (`rf_sdo_oe`=0, `rf_sdo`=0) and read/write flag low. `busy`, `done` and `rd_valid` are low and `rd_data` is zero.
- R2: `req_ack` is high in exactly those cycles in which the block is idle and `req_valid` is high. `busy` is high from the cycle after acceptance until the transfer completes. A request made while busy is neither acknowledged nor acted on.
- R3: Each transfer starts with enable high for `PRE_UNITS` units and then enable low for `SETUP_UNITS` units. The clock is low and the data line is driven to 0 during both. One unit is `DIV` cycles.
- R4: A write shifts the 16-bit frame {data[11:0], addr[3:0]} out MSB first, with address bit 4 ignored. Bits go in pairs of four units each: first bit with clock low, first bit with clock high, second bit with clock high, second bit with clock low.
- R5: After the last write bit, enable is high for `HOLD_UNITS` units with the clock low. Then `busy` drops and `done` is high for one cycle.
- R6: A read sends its 5 address bits MSB first. Each bit takes one unit with the clock low and one with the clock high, and the read/write flag is low.
- R7: After the address comes one turnaround unit with the clock low, the data line released and the read/write flag high. The line stays released and the flag stays high until the read ends.
- R8: A read receives 12 bits MSB first. Each bit takes five units: clock low, then clock high for three units, then clock low. `rf_sdi` is sampled in the last cycle of the third high unit.
- R9: A read ends with one unit of enable high and the read/write flag high. In the next cycle `rd_valid` and `done` pulse together with `rd_data`, which keeps its value until a later host read completes.
- R10: A write with `req_verify` set is followed, without an idle cycle, by a read of address {0, addr[3:0]}. This read gives no `rd_valid`.
- R11: If bits [11:7] of that readback differ from the written data, the write frame is repeated once and then `done` pulses. If they match, `done` pulses directly. A difference only in bits [6:0] causes no rewrite.
- R12: Every accepted request ends in exactly one single-cycle `done` pulse, in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ack | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_verify | input | 1 | Read back and check after a write |
| req_addr | input | 5 | Register address (writes use bits [3:0]) |
| req_data | input | 12 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 12 | Last host read result |
| rf_sen_n | output | 1 | Frame enable, active low |
| rf_sclk | output | 1 | Serial clock |
| rf_sdo | output | 1 | Serial data driven by the master |
| rf_sdo_oe | output | 1 | Master drives the data line |
| rf_sdi | input | 1 | Serial data from the radio |
| rf_rw | output | 1 | Read/write flag |

## Verification
The bus pins change only at unit boundaries. A wrong phase, sub-step, unit count or bit count therefore shows up at `rf_sen_n`, `rf_sclk`, `rf_sdo` or `rf_rw` within one unit, `DIV` cycles, of the slip, and the cycle-by-cycle comparison catches it there. A wrong shift register shows up as a single wrong data bit in the first unit of the affected bit. A wrong capture or verify decision only shows later: at `rd_data` when the read ends, or as an extra or missing rewrite frame right after the readback. The behavioural radio model also decodes every frame on its own, which confirms bit order apart from the waveform comparison.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;
  // Frame geometry is fixed by the radio's serial protocol.
  localparam int DATA_W  = 12;
  localparam int WADDR_W = 4;
  localparam int RADDR_W = 5;
  localparam int WF_W    = DATA_W + WADDR_W;
  localparam int VFY_LSB = 7;   // lowest data bit compared on readback

  typedef enum logic [3:0] {
    PH_IDLE, PH_PRE, PH_SETUP, PH_WBIT, PH_WHOLD,
    PH_ADDR, PH_TURN, PH_RBIT, PH_REND
  } phase_t;
endpackage

// File: rtl/rf3w_divider.sv
module rf3w_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic unit_end
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign unit_end = run;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == CW'(DIV - 1));

      always_comb begin
        if (!run || wrap) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign unit_end = run && wrap;
    end
  endgenerate
endmodule

// File: rtl/rf3w_rxcap.sv
module rf3w_rxcap #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word;
    if (shift_en) word_d = {word[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_d;
  end
endmodule

// File: rtl/rf3w_wave.sv
module rf3w_wave
  import rf3w_pkg::*;
(
  input  phase_t     phase,
  input  logic [2:0] sub,
  input  logic       bit_i,
  output logic       sen_n,
  output logic       sclk,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       rw
);
  always_comb begin
    sen_n  = 1'b0;
    sclk   = 1'b0;
    sdo    = 1'b0;
    sdo_oe = 1'b1;
    rw     = 1'b0;
    unique case (phase)
      PH_IDLE:  begin sen_n = 1'b1; sdo_oe = 1'b0; end
      PH_PRE,
      PH_WHOLD: sen_n = 1'b1;
      PH_SETUP: ;
      PH_WBIT:  begin sclk = (sub == 3'd1) || (sub == 3'd2); sdo = bit_i; end
      PH_ADDR:  begin sclk = (sub == 3'd1); sdo = bit_i; end
      PH_TURN:  begin sdo_oe = 1'b0; rw = 1'b1; end
      PH_RBIT:  begin sdo_oe = 1'b0; rw = 1'b1;
                      sclk = (sub != 3'd0) && (sub != 3'd4); end
      PH_REND:  begin sen_n = 1'b1; sdo_oe = 1'b0; rw = 1'b1; end
      default:  begin sen_n = 1'b1; sdo_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/rf3w_master.sv
module rf3w_master
  import rf3w_pkg::*;
#(
  parameter int DIV         = 100,
  parameter int PRE_UNITS   = 1,
  parameter int SETUP_UNITS = 5,
  parameter int HOLD_UNITS  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ack,
  input  logic                req_write,
  input  logic                req_verify,
  input  logic [RADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_data,
  output logic                busy,
  output logic                done,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rf_sen_n,
  output logic                rf_sclk,
  output logic                rf_sdo,
  output logic                rf_sdo_oe,
  input  logic                rf_sdi,
  output logic                rf_rw
);
  localparam int MAXU   = (PRE_UNITS > SETUP_UNITS) ?
                          ((PRE_UNITS > HOLD_UNITS) ? PRE_UNITS : HOLD_UNITS) :
                          ((SETUP_UNITS > HOLD_UNITS) ? SETUP_UNITS : HOLD_UNITS);
  localparam int UW     = $clog2(MAXU + 1);
  localparam int BCW    = $clog2(DATA_W + 1);
  localparam int WPAIRS = WF_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  phase_t             phase_q, phase_d;
  logic [2:0]         sub_q, sub_d;
  logic [UW-1:0]      ucnt_q, ucnt_d;
  logic [BCW-1:0]     bcnt_q, bcnt_d;
  logic [WF_W-1:0]    shreg_q, shreg_d;
  logic               is_wr_q, is_wr_d, vfy_q, vfy_d;
  logic               vread_q, vread_d, retry_q, retry_d;
  logic [WADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d, rdat_q, rdat_d;
  logic               done_q, done_d, rdv_q, rdv_d;
  logic               tick, samp;
  logic [DATA_W-1:0]  cap_word;

  rf3w_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_ns), .run(phase_q != PH_IDLE), .unit_end(tick));

  assign samp = (phase_q == PH_RBIT) && (sub_q == 3'd3) && tick;

  rf3w_rxcap #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_ns), .shift_en(samp), .din(rf_sdi), .word(cap_word));

  rf3w_wave u_wave (
    .phase(phase_q), .sub(sub_q), .bit_i(shreg_q[WF_W-1]),
    .sen_n(rf_sen_n), .sclk(rf_sclk), .sdo(rf_sdo), .sdo_oe(rf_sdo_oe), .rw(rf_rw));

  assign req_ack  = (phase_q == PH_IDLE) && req_valid;
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;

  always_comb begin
    phase_d = phase_q;  sub_d   = sub_q;   ucnt_d  = ucnt_q;  bcnt_d = bcnt_q;
    shreg_d = shreg_q;  is_wr_d = is_wr_q; vfy_d   = vfy_q;   vread_d = vread_q;
    retry_d = retry_q;  addr_d  = addr_q;  data_d  = data_q;  rdat_d = rdat_q;
    done_d  = 1'b0;     rdv_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        phase_d = PH_PRE;  ucnt_d = '0;
        is_wr_d = req_write;  vfy_d = req_write && req_verify;
        vread_d = 1'b0;  retry_d = 1'b0;
        addr_d  = req_addr[WADDR_W-1:0];  data_d = req_data;
        shreg_d = req_write ? {req_data, req_addr[WADDR_W-1:0]}
                            : {req_addr, {(WF_W-RADDR_W){1'b0}}};
      end
      PH_PRE: if (tick) begin
        if (ucnt_q == UW'(PRE_UNITS - 1)) begin phase_d = PH_SETUP; ucnt_d = '0; end
        else ucnt_d = ucnt_q + UW'(1);
      end
      PH_SETUP: if (tick) begin
        if (ucnt_q == UW'(SETUP_UNITS - 1)) begin
          phase_d = is_wr_q ? PH_WBIT : PH_ADDR;
          ucnt_d = '0;  sub_d = '0;  bcnt_d = '0;
        end else ucnt_d = ucnt_q + UW'(1);
      end
      PH_WBIT: if (tick) begin
        sub_d = sub_q + 3'd1;
        if (sub_q == 3'd1 || sub_q == 3'd3) shreg_d = {shreg_q[WF_W-2:0], 1'b0};
        if (sub_q == 3'd3) begin
          sub_d = '0;  bcnt_d = bcnt_q + BCW'(1);
          if (bcnt_q == BCW'(WPAIRS - 1)) begin phase_d = PH_WHOLD; ucnt_d = '0; end
        end
      end
      PH_WHOLD: if (tick) begin
        if (ucnt_q == UW'(HOLD_UNITS - 1)) begin
          ucnt_d = '0;
          if (vfy_q && !retry_q) begin
            phase_d = PH_PRE;  is_wr_d = 1'b0;  vread_d = 1'b1;
            shreg_d = {1'b0, addr_q, {(WF_W-RADDR_W){1'b0}}};
          end else begin
            phase_d = PH_IDLE;  done_d = 1'b1;
          end
        end else ucnt_d = ucnt_q + UW'(1);
      end
      PH_ADDR: if (tick) begin
        if (sub_q == 3'd0) sub_d = 3'd1;
        else begin
          sub_d = '0;  shreg_d = {shreg_q[WF_W-2:0], 1'b0};  bcnt_d = bcnt_q + BCW'(1);
          if (bcnt_q == BCW'(RADDR_W - 1)) phase_d = PH_TURN;
        end
      end
      PH_TURN: if (tick) begin
        phase_d = PH_RBIT;  sub_d = '0;  bcnt_d = '0;
      end
      PH_RBIT: if (tick) begin
        if (sub_q == 3'd4) begin
          sub_d = '0;  bcnt_d = bcnt_q + BCW'(1);
          if (bcnt_q == BCW'(DATA_W - 1)) phase_d = PH_REND;
        end else sub_d = sub_q + 3'd1;
      end
      PH_REND: if (tick) begin
        if (vread_q) begin
          vread_d = 1'b0;
          if (cap_word[DATA_W-1:VFY_LSB] != data_q[DATA_W-1:VFY_LSB]) begin
            phase_d = PH_PRE;  ucnt_d = '0;  is_wr_d = 1'b1;  retry_d = 1'b1;
            shreg_d = {data_q, addr_q};
          end else begin
            phase_d = PH_IDLE;  done_d = 1'b1;
          end
        end else begin
          phase_d = PH_IDLE;  done_d = 1'b1;  rdv_d = 1'b1;  rdat_d = cap_word;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= PH_IDLE;  sub_q <= '0;  ucnt_q <= '0;  bcnt_q <= '0;
      shreg_q <= '0;  is_wr_q <= 1'b0;  vfy_q <= 1'b0;  vread_q <= 1'b0;
      retry_q <= 1'b0;  addr_q <= '0;  data_q <= '0;  rdat_q <= '0;
      done_q  <= 1'b0;  rdv_q <= 1'b0;
    end else begin
      phase_q <= phase_d;  sub_q <= sub_d;  ucnt_q <= ucnt_d;  bcnt_q <= bcnt_d;
      shreg_q <= shreg_d;  is_wr_q <= is_wr_d;  vfy_q <= vfy_d;  vread_q <= vread_d;
      retry_q <= retry_d;  addr_q <= addr_d;  data_q <= data_d;  rdat_q <= rdat_d;
      done_q  <= done_d;   rdv_q <= rdv_d;
    end
  end

  // R2
  ack_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    req_ack |=> busy);
  // R3
  sclk_low_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rf_sen_n |-> !rf_sclk);
  // R7
  rw_releases_line_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rf_rw |-> !rf_sdo_oe);
  // R8
  sample_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    samp |-> (rf_sclk && !rf_sdo_oe));
  // R9
  rdvalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_valid |-> done);
  // R12
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);
  // R5
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> ($past(busy) && !busy));
endmodule

// File: tb/tb_rf3w_master.sv
module tb_rf3w_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3, PRE_U = 1, SETUP_U = 3, HOLD_U = 2;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_verify = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [11:0] req_data = '0;
  logic req_ack, busy, done, rd_valid;
  logic [11:0] rd_data;
  logic rf_sen_n, rf_sclk, rf_sdo, rf_sdo_oe, rf_rw;
  logic rf_sdi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf3w_master #(.DIV(DIV), .PRE_UNITS(PRE_U), .SETUP_UNITS(SETUP_U), .HOLD_UNITS(HOLD_U)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_write(req_write), .req_verify(req_verify), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .rf_sen_n(rf_sen_n), .rf_sclk(rf_sclk), .rf_sdo(rf_sdo),
    .rf_sdo_oe(rf_sdo_oe), .rf_sdi(rf_sdi), .rf_rw(rf_rw));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural radio ----------------
  logic [11:0] mem [16];
  logic [11:0] corrupt_mask = '0;
  logic [15:0] slv_wframe_q[$];
  logic [4:0]  slv_raddr_q[$];

  function automatic logic [11:0] slave_val(input logic [4:0] a);
    return mem[a[3:0]] ^ (a[4] ? 12'h5A5 : 12'h000) ^ corrupt_mask;
  endfunction

  logic p_sen = 1'b1, p_sclk = 1'b0, saw_rw = 1'b0;
  logic [15:0] rise_sh, fall_sh;
  int nrise, nfall, rd_idx;
  logic [11:0] rd_val;

  initial for (int i = 0; i < 16; i++) mem[i] = {i[3:0], ~i[3:0], i[3:0] ^ 4'h6};

  always @(negedge clk) begin
    if (p_sen && !rf_sen_n) begin
      rise_sh = '0; fall_sh = '0; nrise = 0; nfall = 0; rd_idx = 0; saw_rw = 0;
    end
    if (!rf_sen_n) begin
      if (rf_rw) saw_rw = 1;
      if (!p_sclk && rf_sclk) begin
        if (rf_sdo_oe) begin rise_sh = {rise_sh[14:0], rf_sdo}; nrise++; end
        else begin
          if (rd_idx == 0) rd_val = slave_val(rise_sh[4:0]);
          if (rd_idx < 12) rf_sdi = rd_val[11 - rd_idx];
          rd_idx++;
        end
      end
      if (p_sclk && !rf_sclk && rf_sdo_oe) begin fall_sh = {fall_sh[14:0], rf_sdo}; nfall++; end
    end
    if (!p_sen && rf_sen_n) begin
      rf_sdi = 1'b0;
      if (saw_rw || rf_rw) begin
        logic [4:0] ea;
        ea = (slv_raddr_q.size() > 0) ? slv_raddr_q.pop_front() : 5'h00;
        // R6 address bits decoded by the radio, MSB first
        chk(nrise == 5 && rise_sh[4:0] == ea, "R6", {27'd0, rise_sh[4:0]}, {27'd0, ea});
        corrupt_mask = '0;
      end else begin
        logic [15:0] fr, ef;
        for (int k = 0; k < 8; k++) begin
          fr[15-2*k] = rise_sh[7-k];
          fr[14-2*k] = fall_sh[7-k];
        end
        ef = (slv_wframe_q.size() > 0) ? slv_wframe_q.pop_front() : 16'h0;
        // R4 write frame decoded by the radio
        chk(nrise == 8 && nfall == 8 && fr == ef, "R4", {16'd0, fr}, {16'd0, ef});
        mem[fr[3:0]] = fr[15:4];
      end
    end
    p_sen = rf_sen_n;
    p_sclk = rf_sclk;
  end

  // ---------------- reference model ----------------
  // entry: busy, sen_n, sclk, oe, sdo, rw, done, rd_valid
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [11:0] rdat_q[$];
  logic [11:0] cur_rdat = '0;
  bit in_reset = 1;

  function automatic logic [7:0] mk(input logic b, s, c, o, d, r);
    return {b, s, c, o, d, r, 2'b00};
  endfunction

  task automatic push_u(input int n, input logic [7:0] v, input string t);
    repeat (n * DIV) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [11:0] d, input string ov);
    logic [15:0] f;
    f = {d, a};
    slv_wframe_q.push_back(f);
    push_u(PRE_U,   mk(1,1,0,1,0,0), ov == "" ? "R3" : ov);
    push_u(SETUP_U, mk(1,0,0,1,0,0), ov == "" ? "R3" : ov);
    for (int k = 0; k < 8; k++) begin
      push_u(1, mk(1,0,0,1,f[15-2*k],0), ov == "" ? "R4" : ov);
      push_u(1, mk(1,0,1,1,f[15-2*k],0), ov == "" ? "R4" : ov);
      push_u(1, mk(1,0,1,1,f[14-2*k],0), ov == "" ? "R4" : ov);
      push_u(1, mk(1,0,0,1,f[14-2*k],0), ov == "" ? "R4" : ov);
    end
    push_u(HOLD_U, mk(1,1,0,1,0,0), ov == "" ? "R5" : ov);
  endtask

  task automatic model_read(input logic [4:0] a, input string ov);
    slv_raddr_q.push_back(a);
    push_u(PRE_U,   mk(1,1,0,1,0,0), ov == "" ? "R3" : ov);
    push_u(SETUP_U, mk(1,0,0,1,0,0), ov == "" ? "R3" : ov);
    for (int i = 0; i < 5; i++) begin
      push_u(1, mk(1,0,0,1,a[4-i],0), ov == "" ? "R6" : ov);
      push_u(1, mk(1,0,1,1,a[4-i],0), ov == "" ? "R6" : ov);
    end
    push_u(1, mk(1,0,0,0,0,1), ov == "" ? "R7" : ov);
    for (int i = 0; i < 12; i++) begin
      push_u(1, mk(1,0,0,0,0,1), ov == "" ? "R8" : ov);
      push_u(3, mk(1,0,1,0,0,1), ov == "" ? "R8" : ov);
      push_u(1, mk(1,0,0,0,0,1), ov == "" ? "R8" : ov);
    end
    push_u(1, mk(1,1,0,0,0,1), ov == "" ? "R9" : ov);
  endtask

  task automatic model_accept();
    if (req_write) begin
      model_write(req_addr[3:0], req_data, "");
      if (req_verify) begin
        logic [11:0] rb;
        rb = req_data ^ corrupt_mask;
        model_read({1'b0, req_addr[3:0]}, "R10");
        if (rb[11:7] != req_data[11:7]) model_write(req_addr[3:0], req_data, "R11");
      end
      exp_q.push_back(mk(0,1,0,0,0,0) | 8'h02); tag_q.push_back("R12");
    end else begin
      rdat_q.push_back(slave_val(req_addr));
      model_read(req_addr, "");
      exp_q.push_back(mk(0,1,0,0,0,0) | 8'h03); tag_q.push_back("R9");
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e, act;
    string t;
    cyc++;
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
    else begin e = mk(0,1,0,0,0,0); t = in_reset ? "R1" : "R12"; end
    act = {busy, rf_sen_n, rf_sclk, rf_sdo_oe, rf_sdo, rf_rw, done, rd_valid};
    chk(act == e, t, {24'd0, act}, {24'd0, e});
    if (e[0] && rdat_q.size() > 0) cur_rdat = rdat_q.pop_front();
    // R9 read result and its hold; R1 zero after reset
    chk(rd_data == cur_rdat, in_reset ? "R1" : "R9", {20'd0, rd_data}, {20'd0, cur_rdat});
    // R2 acknowledge only when idle
    chk(req_ack == (!e[7] && req_valid), "R2", {31'd0, req_ack}, {31'd0, !e[7] && req_valid});
    if (req_valid && req_ack) model_accept();
    if (cyc > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic w, input logic v, input logic [4:0] a, input logic [11:0] d);
    @(posedge clk); #1;
    req_write = w; req_verify = v; req_addr = a; req_data = d; req_valid = 1'b1;
    do @(negedge clk); while (!req_ack);
    @(posedge clk); #1 req_valid = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (5) @(posedge clk);           // R1 checked every cycle of reset
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    in_reset = 0;
    issue(1, 0, 5'h05, 12'h3C7);         // R4 R5 basic write
    issue(1, 0, 5'h0F, 12'hA5A);
    issue(1, 0, 5'h13, 12'h0F1);         // R4 address bit 4 ignored on writes
    issue(0, 0, 5'h05, 12'h000);         // R8 R9 read back written value
    issue(0, 0, 5'h1A, 12'h000);         // R6 address bit 4 on reads
    issue(0, 0, 5'h03, 12'h000);
    // R2 requests while busy are ignored
    @(posedge clk); #1;
    req_write = 1; req_verify = 0; req_addr = 5'h02; req_data = 12'h6B4; req_valid = 1;
    do @(negedge clk); while (!req_ack);
    @(posedge clk); #1;
    req_write = 0; req_addr = 5'h0C;
    repeat (30) @(posedge clk);
    #1 req_valid = 0;
    do @(negedge clk); while (!done);
    issue(1, 1, 5'h07, 12'h380);         // R10 verify, match
    corrupt_mask = 12'h080;
    issue(1, 1, 5'h08, 12'h2C1);         // R11 mismatch in upper bits -> rewrite
    corrupt_mask = 12'h07F;
    issue(1, 1, 5'h07, 12'h155);         // R11 low-bit difference -> no rewrite
    issue(0, 0, 5'h07, 12'h000);
    issue(0, 0, 5'h08, 12'h000);
    issue(1, 0, 5'h0C, 12'hFFF);         // R9 rd_data held across a write
    issue(0, 0, 5'h0C, 12'h000);
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule